// File: doc/BRIEF.md
# Synchronization pulse conditioner

This block turns one of four asynchronous reference signals into a clean, single-cycle SYNC pulse in the oscillator clock domain. That pulse is the restart event for a frequency error counter. Each reference is brought into the oscillator domain by a flop synchroniser. Rising and falling transitions are detected on every reference, so changing the source or the polarity never creates a false transition. The chosen edge stream then passes through a power-of-two prescaler. A software sync request is merged with the prescaled pulse.

The configuration has three fields: source, active edge and divide code. It is captured from a write strobe only while the measurement counter enable is low, and it is shown on output ports. The prescaler restarts from zero when a configuration write is accepted and when the counter enable rises. While the enable is low, no SYNC pulse is produced and no edges are counted.

Top module: `sync_pulse_conditioner`

## Requirements
- R1: The source code `srcSelIn` picks the reference input with the same index. Code 0 is the external sync pin, 1 the low-speed crystal clock, 2 the first start-of-frame pulse and 3 the second start-of-frame pulse. Transitions on the other inputs have no effect.
- R2: When `fallEdgeIn` is 0, a rising transition of the selected reference is the active event. When it is 1, a falling transition is the active event.
- R3: With divide code n (0 to 7) on `divCodeIn`, one SYNC pulse is produced for every 2^n active edges. Code 0 passes every edge and code 7 passes one edge in 128.
- R4: A one-cycle `swSyncReq` while the enable is high gives exactly one SYNC pulse on the next cycle. If it coincides with a prescaled hardware pulse, the two give a single one-cycle SYNC.
- R5: A write with `cfgWrite` is taken only while `cntEnable` is low. While the enable is high, the write is ignored and the configuration outputs do not change.
- R6: The prescaler restarts from zero on an accepted configuration write and on a rising `cntEnable`. The first SYNC pulse after either event therefore needs a full 2^n active edges.
- R7: An active transition on a reference pin gives its SYNC pulse three clock edges after the pin changes: two synchroniser stages, then the output register. The pulse is one cycle wide.
- R8: While `cntEnable` is low, there is no SYNC pulse, active edges are not counted, and software requests are ignored.
- R9: After reset, `syncPulse` is 0, the source is 2, the edge selection is rising (0) and the divide code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refIn | input | 4 | Asynchronous reference inputs, index equals source code |
| cntEnable | input | 1 | Measurement counter enable, locks the configuration when high |
| cfgWrite | input | 1 | Configuration write strobe |
| srcSelIn | input | 2 | Source code to write |
| fallEdgeIn | input | 1 | Edge selection to write, 1 = falling |
| divCodeIn | input | 3 | log2 divide code to write |
| swSyncReq | input | 1 | Software sync request, one-cycle strobe |
| syncPulse | output | 1 | One-cycle SYNC pulse |
| srcSel | output | 2 | Current source code |
| fallEdge | output | 1 | Current edge selection |
| divCode | output | 3 | Current divide code |

## Verification
A prescaler count that is corrupted or not restarted moves SYNC pulses to the wrong edge. This shows at the port as a pulse missing from, or added to, the expected cycle within 2^n active edges. A wrong source or edge choice shows as a pulse on the first transition of the wrong input, or as no pulse at all. A broken lock shows on the configuration outputs one cycle after the ignored write. The scoreboard expects every pulse in an exact cycle, so any shift of even one cycle is reported.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;
  localparam int SRC_W = 2;
  localparam int DIV_W = 3;

  typedef struct packed {
    logic [SRC_W-1:0] srcSel;
    logic             fallEdge;
    logic [DIV_W-1:0] divCode;
  } syncCfg_t;

  typedef struct packed {
    logic clearPresc;  // restart prescaler
    logic countEn;     // edges may be counted, pulses may leave
    logic swFire;      // accepted software request
  } syncStrobe_t;

  localparam syncCfg_t CFG_RESET = '{srcSel: 2'b10, fallEdge: 1'b0, divCode: '0};
endpackage

// File: rtl/sync_cond_ctrl.sv
module sync_cond_ctrl
  import sync_cond_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntEnable,
  input  logic        cfgWrite,
  input  syncCfg_t    cfgIn,
  input  logic        swSyncReq,
  output syncCfg_t    cfg,
  output syncStrobe_t strobe
);
  logic enPrev;
  logic cfgAccept;

  assign cfgAccept = cfgWrite && !cntEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= CFG_RESET;
      enPrev <= 1'b0;
    end else begin
      enPrev <= cntEnable;
      if (cfgAccept) cfg <= cfgIn;
    end
  end

  always_comb begin
    strobe.clearPresc = cfgAccept || (cntEnable && !enPrev);
    strobe.countEn    = cntEnable;
    strobe.swFire     = swSyncReq && cntEnable;
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    cntEnable |=> $stable(cfg)); // R5
endmodule

// File: rtl/sync_cond_path.sv
module sync_cond_path
  import sync_cond_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] refIn,
  input  syncCfg_t           cfg,
  input  syncStrobe_t        strobe,
  output logic               syncPulse
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [NUM_SRC-1:0] riseEv;
  logic [NUM_SRC-1:0] fallEv;
  logic [CNT_W-1:0]   prescCnt;
  logic [CNT_W-1:0]   divMask;
  logic               selEdge;
  logic               divTick;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] stage;
    logic                   prevLvl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage   <= '0;
        prevLvl <= 1'b0;
      end else begin
        stage   <= {stage[SYNC_STAGES-2:0], refIn[i]};
        prevLvl <= stage[SYNC_STAGES-1];
      end
    end
    assign riseEv[i] = stage[SYNC_STAGES-1] && !prevLvl;
    assign fallEv[i] = !stage[SYNC_STAGES-1] && prevLvl;
  end

  always_comb begin
    selEdge = cfg.fallEdge ? fallEv[cfg.srcSel] : riseEv[cfg.srcSel];
    divMask = ~({CNT_W{1'b1}} << cfg.divCode);
    divTick = strobe.countEn && !strobe.clearPresc && selEdge && (prescCnt == divMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt  <= '0;
      syncPulse <= 1'b0;
    end else begin
      if (strobe.clearPresc)                prescCnt <= '0;
      else if (strobe.countEn && selEdge)   prescCnt <= divTick ? '0 : prescCnt + 1'b1;
      syncPulse <= divTick || strobe.swFire;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    prescCnt <= divMask); // R3
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearPresc |=> prescCnt == '0); // R6
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.countEn |=> !syncPulse); // R8
  AST_SW_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swFire |=> syncPulse); // R4
endmodule

// File: rtl/sync_pulse_conditioner.sv
module sync_pulse_conditioner
  import sync_cond_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] refIn,
  input  logic               cntEnable,
  input  logic               cfgWrite,
  input  logic [SRC_W-1:0]   srcSelIn,
  input  logic               fallEdgeIn,
  input  logic [DIV_W-1:0]   divCodeIn,
  input  logic               swSyncReq,
  output logic               syncPulse,
  output logic [SRC_W-1:0]   srcSel,
  output logic               fallEdge,
  output logic [DIV_W-1:0]   divCode
);
  syncCfg_t    cfgIn;
  syncCfg_t    cfg;
  syncStrobe_t strobe;

  assign cfgIn = '{srcSel: srcSelIn, fallEdge: fallEdgeIn, divCode: divCodeIn};

  sync_cond_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .cfgWrite(cfgWrite),
    .cfgIn(cfgIn), .swSyncReq(swSyncReq), .cfg(cfg), .strobe(strobe)
  );

  sync_cond_path #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .refIn(refIn), .cfg(cfg), .strobe(strobe),
    .syncPulse(syncPulse)
  );

  assign srcSel   = cfg.srcSel;
  assign fallEdge = cfg.fallEdge;
  assign divCode  = cfg.divCode;
endmodule

// File: tb/test_sync_pulse_conditioner.sv
module test_sync_pulse_conditioner;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] refIn = '0;
  logic       cntEnable = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [1:0] srcSelIn = '0;
  logic       fallEdgeIn = 1'b0;
  logic [2:0] divCodeIn = '0;
  logic       swSyncReq = 1'b0;
  logic       syncPulse;
  logic [1:0] srcSel;
  logic       fallEdge;
  logic [2:0] divCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_pulse_conditioner i_sync_pulse_conditioner (
    .clk(clk), .rstN(rstN), .refIn(refIn), .cntEnable(cntEnable),
    .cfgWrite(cfgWrite), .srcSelIn(srcSelIn), .fallEdgeIn(fallEdgeIn),
    .divCodeIn(divCodeIn), .swSyncReq(swSyncReq), .syncPulse(syncPulse),
    .srcSel(srcSel), .fallEdge(fallEdge), .divCode(divCode)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int expQ[$];
  bit monOn = 1'b0;
  string curReq = "R9";
  // bench model of the configuration and prescaler
  int mSrc = 2, mFall = 0, mDiv = 0, mEn = 0, mCnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every SYNC must match the head of the expected queue
  always @(negedge clk) if (monOn) begin
    if (expQ.size() > 0 && expQ[0] < cyc) begin
      checks++; errors++;
      $display("FAIL %s missing SYNC: actual none, expected at cycle %0d", curReq, expQ[0]);
      void'(expQ.pop_front());
    end
    if (syncPulse) begin
      checks++;
      if (expQ.size() > 0 && expQ[0] == cyc) void'(expQ.pop_front());
      else begin
        errors++;
        $display("FAIL %s unexpected SYNC: actual cycle %0d, expected %0d", curReq, cyc,
                 expQ.size() > 0 ? expQ[0] : -1);
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) if (cyc > 60000) begin
    errors++;
    $display("FAIL watchdog: actual cycle %0d, expected finish earlier", cyc);
    summary();
    $finish;
  end

  // driver: toggle one reference, push the expected SYNC cycle; returns 1 if pushed
  task automatic edgeDrive(input int idx, output bit pushed);
    bit lvl;
    pushed = 1'b0;
    lvl = ~refIn[idx];
    refIn[idx] = lvl;
    if (mEn != 0 && idx == mSrc && (lvl == (mFall == 0))) begin
      mCnt++;
      if (mCnt == (1 << mDiv)) begin
        expQ.push_back(cyc + 3);  // R7: two stages + output register
        mCnt = 0;
        pushed = 1'b1;
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic edges(input int idx, input int n);
    bit p;
    for (int k = 0; k < n; k++) edgeDrive(idx, p);
  endtask

  task automatic drain();
    repeat (5) @(negedge clk);
  endtask

  task automatic setEnable(input int v);
    cntEnable = v[0];
    if (v != 0 && mEn == 0) mCnt = 0;
    mEn = v;
    @(negedge clk);
  endtask

  task automatic swPulse();
    swSyncReq = 1'b1;
    if (mEn != 0) expQ.push_back(cyc + 1);
    @(negedge clk);
    swSyncReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkCfg(input string req);
    checks++;
    if (srcSel != mSrc[1:0] || fallEdge != mFall[0] || divCode != mDiv[2:0]) begin
      errors++;
      $display("FAIL %s cfg: actual src %0d fall %0d div %0d, expected src %0d fall %0d div %0d",
               req, srcSel, fallEdge, divCode, mSrc, mFall, mDiv);
    end
  endtask

  task automatic writeCfg(input int s, input int f, input int d);
    srcSelIn = s[1:0]; fallEdgeIn = f[0]; divCodeIn = d[2:0]; cfgWrite = 1'b1;
    if (mEn == 0) begin mSrc = s; mFall = f; mDiv = d; mCnt = 0; end
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  initial begin
    bit p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    checks++;
    if (syncPulse !== 1'b0) begin
      errors++; $display("FAIL R9 syncPulse: actual %0b, expected 0", syncPulse);
    end
    checkCfg("R9");
    monOn = 1'b1;

    // R1 default source 2, rising, no division; other inputs ignored
    curReq = "R1";
    setEnable(1);
    edges(2, 6);
    edges(0, 4);
    edges(3, 4);
    drain();

    // R2 R3 falling edge on source 0, divide by 4
    curReq = "R3";
    setEnable(0);
    writeCfg(0, 1, 2);
    checkCfg("R2");
    setEnable(1);
    edges(0, 16);
    edges(2, 4);
    drain();

    // R5 write while enabled is ignored, counting continues unchanged
    curReq = "R5";
    writeCfg(3, 0, 0);
    checkCfg("R5");
    edges(0, 8);
    drain();

    // R6 restart on enable rise: three edges then restart
    curReq = "R6";
    edges(0, 6);
    drain();
    setEnable(0);
    setEnable(1);
    edges(0, 6);
    drain();
    edges(0, 2);
    drain();

    // R4 software request
    curReq = "R4";
    swPulse();
    swPulse();
    drain();

    // R8 disabled: no pulses, no counting, requests ignored
    curReq = "R8";
    setEnable(0);
    swPulse();
    edges(0, 8);
    drain();
    setEnable(1);
    edges(0, 8);
    drain();

    // R3 divide by 128 on source 1 rising
    curReq = "R3";
    setEnable(0);
    writeCfg(1, 0, 7);
    checkCfg("R3");
    setEnable(1);
    edges(1, 256);
    drain();

    // R4 coincident hardware and software pulse give one SYNC
    curReq = "R4";
    setEnable(0);
    writeCfg(2, 0, 0);
    checkCfg("R4");
    setEnable(1);
    if (refIn[2]) edges(2, 1);
    drain();
    edgeDrive(2, p);      // hardware SYNC expected at toggle cycle + 3
    swSyncReq = 1'b1;     // captured on the same edge as the hardware pulse
    if (!p) expQ.push_back(cyc + 1);
    @(negedge clk);
    swSyncReq = 1'b0;
    drain();

    // R7 latency on the rising edge of source 2
    curReq = "R7";
    edges(2, 4);
    drain();

    checks++;
    if (expQ.size() != 0) begin
      errors++; $display("FAIL R7 pending SYNC: actual %0d left, expected 0", expQ.size());
    end
    summary();
    $finish;
  end
endmodule